// File: doc/BRIEF.md
# Banked Data Memory with Pointer-Based Indirection

This block is the data memory of a small 8-bit microcontroller core. It takes an 8-bit address space. The lower 64 locations hold special functions. The upper 192 locations hold general-purpose RAM, and a bank input selects which bank of that RAM is seen. Three special registers live inside the block: two 8-bit pointers at 01H and 03H, and the accumulator at 05H. Locations 00H and 02H have no storage. An access to either of them is redirected, in the same cycle, to the byte named by the first or the second pointer.

The core supplies three things: a combinational read port, a byte write port, and a bit-operation request. A bit operation is a read-modify-write on the byte the read port addresses, and it completes in one clock. Special-function addresses 06H–1FH are not stored here. They are passed through to an external port, where the core's other special registers sit. All other addresses below 40H are reserved. Everything below 40H looks the same whichever bank is selected.

Top module: `dmem_core`

## Requirements
- R1: A write to 01H, 03H or 05H loads the first pointer, the second pointer or the accumulator at the next rising edge. A read of those addresses returns the held value in the same cycle.
- R2: A read or write of 00H acts on the byte whose address is held in the first pointer. That address is resolved in the same cycle as the access.
- R3: A read or write of 02H acts on the byte whose address is held in the second pointer.
- R4: If the pointer used by an indirect access holds 00H or 02H, the read returns 00H and the write changes no pointer, accumulator, RAM byte or external register.
- R5: Reserved addresses (04H and 20H–3FH) read as 00H. Writes to them are ignored.
- R6: Addresses 06H–1FH, whether direct or reached through a pointer, go to the external port. A read raises `x_rsel`, puts the address on `x_raddr` and returns `x_rdata`. A write raises `x_we` in the same cycle, with `x_waddr` and `x_wdata`. No other address raises `x_we`.
- R7: Locations below 40H give the same result for every value of `bank_sel`.
- R8: With `bank_sel` = 0, addresses 40H–FFH address 192 bytes of RAM. A write there is visible to a read from the next cycle on.
- R9: With `bank_sel` nonzero (no such bank), reads of 40H–FFH return 00H and writes there are ignored.
- R10: When `bop_en` is high, bit `bop_idx` (0 is the least significant bit) of the byte at `rd_addr` is set when `bop_set` = 1 and cleared when `bop_set` = 0. Pointer redirection applies. The other seven bits are kept. The result is stored at the next rising edge.
- R11: When `bop_en` and `wr_en` are both high, the bit operation is performed and the byte write is dropped.
- R12: A bit operation on an external address drives `x_we` with `x_waddr` set to that address and `x_wdata` set to `x_rdata` with the chosen bit changed.
- R13: After reset, both pointers and the accumulator hold 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | BANK_W | Bank for the general-purpose region |
| rd_addr | input | 8 | Read address; also the bit-operation target |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 8 | Byte write address |
| wr_data | input | 8 | Byte write data |
| bop_en | input | 1 | Bit-operation request on the byte at rd_addr |
| bop_set | input | 1 | 1 = set the bit, 0 = clear it |
| bop_idx | input | 3 | Bit index |
| ptr0_o | output | 8 | First pointer value |
| ptr1_o | output | 8 | Second pointer value |
| acc_o | output | 8 | Accumulator value |
| x_rsel | output | 1 | Read targets the external window |
| x_raddr | output | 8 | Resolved external read address |
| x_rdata | input | 8 | External read data |
| x_we | output | 1 | External write strobe |
| x_waddr | output | 8 | Resolved external write address |
| x_wdata | output | 8 | External write data |

## Verification
Reads, including pointer redirection and the external read select, settle in the cycle the address is presented. The external write strobe also appears in that same cycle. Pointer, accumulator and RAM updates, whether from byte writes or bit operations, show up only after the next rising edge. The bench applies each stimulus on a falling edge. It samples combinational results 1 ns later, before the next rising edge. Stored results are checked by a read issued on the falling edge after the commit edge.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int unsigned DW = 8;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PTR0,
        TGT_PTR1,
        TGT_ACC,
        TGT_EXT,
        TGT_GPR
    } tgt_e;

    localparam logic [7:0] LOC_IND0 = 8'h00;
    localparam logic [7:0] LOC_PTR0 = 8'h01;
    localparam logic [7:0] LOC_IND1 = 8'h02;
    localparam logic [7:0] LOC_PTR1 = 8'h03;
    localparam logic [7:0] LOC_ACC  = 8'h05;

    typedef struct packed {
        logic [DW-1:0] ptr0;
        logic [DW-1:0] ptr1;
        logic [DW-1:0] acc;
    } core_regs_t;

    function automatic logic [DW-1:0] bit_apply(logic [DW-1:0] v, logic [2:0] idx, logic set);
        logic [DW-1:0] r;
        r      = v;
        r[idx] = set;
        return r;
    endfunction

endpackage

// File: rtl/dmem_resolve.sv
module dmem_resolve
    import dmem_pkg::*;
#(
    parameter logic [7:0] EXT_LO  = 8'h06,
    parameter logic [7:0] EXT_HI  = 8'h1F,
    parameter logic [7:0] GP_BASE = 8'h40
) (
    input  logic [7:0] addr,
    input  logic [7:0] ptr0,
    input  logic [7:0] ptr1,
    output logic [7:0] ea,
    output tgt_e       tgt
);

    always_comb begin
        if (addr == LOC_IND0)      ea = ptr0;
        else if (addr == LOC_IND1) ea = ptr1;
        else                       ea = addr;

        // an effective address of an indirect slot means nested indirection
        if (ea == LOC_IND0 || ea == LOC_IND1)     tgt = TGT_NONE;
        else if (ea == LOC_PTR0)                  tgt = TGT_PTR0;
        else if (ea == LOC_PTR1)                  tgt = TGT_PTR1;
        else if (ea == LOC_ACC)                   tgt = TGT_ACC;
        else if (ea >= GP_BASE)                   tgt = TGT_GPR;
        else if (ea >= EXT_LO && ea <= EXT_HI)    tgt = TGT_EXT;
        else                                      tgt = TGT_NONE;
    end

endmodule

// File: rtl/dmem_gpr.sv
module dmem_gpr #(
    parameter int unsigned   BANKS   = 1,
    parameter int unsigned   BANK_W  = 3,
    parameter int unsigned   DW      = 8,
    parameter logic [7:0]    GP_BASE = 8'h40
) (
    input  logic              clk,
    input  logic [BANK_W-1:0] bank,
    input  logic              we,
    input  logic [7:0]        waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [7:0]        raddr,
    output logic [DW-1:0]     rdata
);

    localparam int unsigned DEPTH = 256 - int'(GP_BASE);
    localparam logic [BANK_W:0] BANKS_L = (BANK_W+1)'(BANKS);

    logic [7:0]    woff_d, roff_d;
    logic          bank_ok_d;
    logic [DW-1:0] bank_rd [BANKS];

    assign woff_d    = waddr - GP_BASE;
    assign roff_d    = raddr - GP_BASE;
    assign bank_ok_d = {1'b0, bank} < BANKS_L;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DW-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && bank == BANK_W'(b)) mem_q[woff_d] <= wdata;
        end

        assign bank_rd[b] = mem_q[roff_d];
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_ok_d && bank == BANK_W'(b)) rdata = bank_rd[b];
        end
    end

endmodule

// File: rtl/dmem_core.sv
module dmem_core
    import dmem_pkg::*;
#(
    parameter int unsigned BANKS   = 1,
    parameter int unsigned BANK_W  = 3,
    parameter logic [7:0]  EXT_LO  = 8'h06,
    parameter logic [7:0]  EXT_HI  = 8'h1F,
    parameter logic [7:0]  GP_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              bop_en,
    input  logic              bop_set,
    input  logic [2:0]        bop_idx,
    output logic [7:0]        ptr0_o,
    output logic [7:0]        ptr1_o,
    output logic [7:0]        acc_o,
    output logic              x_rsel,
    output logic [7:0]        x_raddr,
    input  logic [7:0]        x_rdata,
    output logic              x_we,
    output logic [7:0]        x_waddr,
    output logic [7:0]        x_wdata
);

    localparam logic [BANK_W:0] BANKS_L = (BANK_W+1)'(BANKS);

    core_regs_t regs_d, regs_q;

    logic [7:0] rd_ea, wr_ea;
    tgt_e       rd_tgt, wr_tgt;
    logic [7:0] gpr_rd;

    logic       cm_en_d;
    logic [7:0] cm_ea_d, cm_data_d;
    tgt_e       cm_tgt_d;

    dmem_resolve #(.EXT_LO(EXT_LO), .EXT_HI(EXT_HI), .GP_BASE(GP_BASE)) u_rd_res (
        .addr(rd_addr), .ptr0(regs_q.ptr0), .ptr1(regs_q.ptr1),
        .ea(rd_ea), .tgt(rd_tgt)
    );

    dmem_resolve #(.EXT_LO(EXT_LO), .EXT_HI(EXT_HI), .GP_BASE(GP_BASE)) u_wr_res (
        .addr(wr_addr), .ptr0(regs_q.ptr0), .ptr1(regs_q.ptr1),
        .ea(wr_ea), .tgt(wr_tgt)
    );

    dmem_gpr #(.BANKS(BANKS), .BANK_W(BANK_W), .DW(DW), .GP_BASE(GP_BASE)) u_gpr (
        .clk(clk), .bank(bank_sel),
        .we(cm_en_d && cm_tgt_d == TGT_GPR), .waddr(cm_ea_d), .wdata(cm_data_d),
        .raddr(rd_ea), .rdata(gpr_rd)
    );

    // read mux
    always_comb begin
        unique case (rd_tgt)
            TGT_PTR0: rd_data = regs_q.ptr0;
            TGT_PTR1: rd_data = regs_q.ptr1;
            TGT_ACC:  rd_data = regs_q.acc;
            TGT_EXT:  rd_data = x_rdata;
            TGT_GPR:  rd_data = gpr_rd;
            default:  rd_data = '0;
        endcase
    end

    // commit selection: a bit operation takes priority over a byte write
    always_comb begin
        if (bop_en) begin
            cm_en_d   = 1'b1;
            cm_ea_d   = rd_ea;
            cm_tgt_d  = rd_tgt;
            cm_data_d = bit_apply(rd_data, bop_idx, bop_set);
        end else begin
            cm_en_d   = wr_en;
            cm_ea_d   = wr_ea;
            cm_tgt_d  = wr_tgt;
            cm_data_d = wr_data;
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (cm_en_d) begin
            case (cm_tgt_d)
                TGT_PTR0: regs_d.ptr0 = cm_data_d;
                TGT_PTR1: regs_d.ptr1 = cm_data_d;
                TGT_ACC:  regs_d.acc  = cm_data_d;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ptr0_o  = regs_q.ptr0;
    assign ptr1_o  = regs_q.ptr1;
    assign acc_o   = regs_q.acc;
    assign x_rsel  = (rd_tgt == TGT_EXT);
    assign x_raddr = rd_ea;
    assign x_we    = cm_en_d && cm_tgt_d == TGT_EXT;
    assign x_waddr = cm_ea_d;
    assign x_wdata = cm_data_d;

    // R1
    ptr0_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bop_en && wr_addr == LOC_PTR0) |=> ptr0_o == $past(wr_data));

    // R4
    nested_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == LOC_IND0 && (ptr0_o == LOC_IND0 || ptr0_o == LOC_IND1)) |-> rd_data == 8'h00);

    // R4
    nested_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bop_en && wr_addr == LOC_IND0 && ptr0_o == LOC_IND1)
        |=> ($stable(ptr0_o) && $stable(ptr1_o) && $stable(acc_o)));

    // R5
    resv_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 8'h04 || (rd_addr > EXT_HI && rd_addr < GP_BASE)) |-> rd_data == 8'h00);

    // R6
    x_we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_we |-> (x_waddr >= EXT_LO && x_waddr <= EXT_HI));

    // R9
    bank_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, bank_sel} >= BANKS_L && rd_addr >= GP_BASE) |-> rd_data == 8'h00);

    // R10
    bop_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bop_en && rd_addr == LOC_ACC) |=> acc_o[$past(bop_idx)] == $past(bop_set));

endmodule

// File: tb/dmem_core_test.sv
module dmem_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bank_sel = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       bop_en = 1'b0;
    logic       bop_set = 1'b0;
    logic [2:0] bop_idx = '0;
    logic [7:0] ptr0_o, ptr1_o, acc_o;
    logic       x_rsel, x_we;
    logic [7:0] x_raddr, x_rdata, x_waddr, x_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    // external register model: data derived from address
    assign x_rdata = x_raddr ^ 8'hA5;

    dmem_core uut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bop_en(bop_en), .bop_set(bop_set), .bop_idx(bop_idx),
        .ptr0_o(ptr0_o), .ptr1_o(ptr1_o), .acc_o(acc_o),
        .x_rsel(x_rsel), .x_raddr(x_raddr), .x_rdata(x_rdata),
        .x_we(x_we), .x_waddr(x_waddr), .x_wdata(x_wdata)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic do_bop(logic [7:0] a, logic [2:0] idx, logic set);
        @(negedge clk);
        bop_en = 1'b1; rd_addr = a; bop_idx = idx; bop_set = set;
        @(negedge clk);
        bop_en = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R13", 8'h01, 8'h00);
        rd_chk("R13", 8'h03, 8'h00);
        rd_chk("R13", 8'h05, 8'h00);
    endtask

    task automatic t_direct;
        do_wr(8'h01, 8'h45); rd_chk("R1", 8'h01, 8'h45);
        do_wr(8'h03, 8'h80); rd_chk("R1", 8'h03, 8'h80);
        do_wr(8'h05, 8'h3C); rd_chk("R1", 8'h05, 8'h3C);
        chk("R1", acc_o, 8'h3C);
    endtask

    task automatic t_gpr;
        do_wr(8'h40, 8'h11);
        do_wr(8'hFF, 8'h22);
        rd_chk("R8", 8'h40, 8'h11);
        rd_chk("R8", 8'hFF, 8'h22);
    endtask

    task automatic t_ind0;
        do_wr(8'h01, 8'h47);
        do_wr(8'h00, 8'h5A);
        rd_chk("R2", 8'h47, 8'h5A);
        rd_chk("R2", 8'h00, 8'h5A);
        do_wr(8'h01, 8'h05);
        do_wr(8'h00, 8'h66);
        rd_chk("R2", 8'h05, 8'h66);
    endtask

    task automatic t_ind1;
        do_wr(8'h03, 8'h90);
        do_wr(8'h02, 8'hC3);
        rd_chk("R3", 8'h90, 8'hC3);
        rd_chk("R3", 8'h02, 8'hC3);
    endtask

    task automatic t_nested;
        do_wr(8'h01, 8'h02);
        rd_chk("R4", 8'h00, 8'h00);
        do_wr(8'h00, 8'h77);
        rd_chk("R4", 8'h03, 8'h90);
        rd_chk("R4", 8'h05, 8'h66);
        rd_chk("R4", 8'h01, 8'h02);
        do_wr(8'h03, 8'h00);
        rd_chk("R4", 8'h02, 8'h00);
        do_wr(8'h02, 8'h99);
        rd_chk("R4", 8'h01, 8'h02);
        rd_chk("R4", 8'h03, 8'h00);
    endtask

    task automatic t_reserved;
        do_wr(8'h04, 8'hFF);
        do_wr(8'h30, 8'hFF);
        rd_chk("R5", 8'h04, 8'h00);
        rd_chk("R5", 8'h30, 8'h00);
        rd_chk("R5", 8'h3F, 8'h00);
        rd_chk("R5", 8'h20, 8'h00);
    endtask

    task automatic t_ext;
        rd_chk("R6", 8'h0A, 8'hAF);
        chk("R6", {7'd0, x_rsel}, 8'h01);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h0A; wr_data = 8'h12;
        #1;
        chk("R6", {7'd0, x_we}, 8'h01);
        chk("R6", x_waddr, 8'h0A);
        chk("R6", x_wdata, 8'h12);
        @(negedge clk);
        wr_addr = 8'h30;
        #1;
        chk("R6", {7'd0, x_we}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        do_wr(8'h01, 8'h0B);
        rd_chk("R6", 8'h00, 8'hAE);
        chk("R6", x_raddr, 8'h0B);
    endtask

    task automatic t_bank;
        @(negedge clk); bank_sel = 3'd3;
        rd_chk("R7", 8'h01, 8'h0B);
        rd_chk("R7", 8'h05, 8'h66);
        rd_chk("R9", 8'h40, 8'h00);
        do_wr(8'h40, 8'hEE);
        @(negedge clk); bank_sel = 3'd0;
        rd_chk("R9", 8'h40, 8'h11);
        rd_chk("R8", 8'hFF, 8'h22);
    endtask

    task automatic t_bit;
        do_wr(8'h05, 8'h3C);
        do_bop(8'h05, 3'd0, 1'b1);
        rd_chk("R10", 8'h05, 8'h3D);
        do_bop(8'h05, 3'd5, 1'b0);
        rd_chk("R10", 8'h05, 8'h1D);
        do_wr(8'h03, 8'h90);
        do_bop(8'h02, 3'd7, 1'b0);
        rd_chk("R10", 8'h90, 8'h43);
    endtask

    task automatic t_prio;
        @(negedge clk);
        bop_en = 1'b1; rd_addr = 8'h05; bop_idx = 3'd7; bop_set = 1'b1;
        wr_en = 1'b1; wr_addr = 8'h05; wr_data = 8'h00;
        @(negedge clk);
        bop_idx = 3'd1; wr_addr = 8'h40; wr_data = 8'h55;
        @(negedge clk);
        bop_en = 1'b0; wr_en = 1'b0;
        rd_chk("R11", 8'h05, 8'h9F);
        rd_chk("R11", 8'h40, 8'h11);
    endtask

    task automatic t_bitext;
        @(negedge clk);
        bop_en = 1'b1; rd_addr = 8'h0A; bop_idx = 3'd0; bop_set = 1'b0;
        #1;
        chk("R12", {7'd0, x_we}, 8'h01);
        chk("R12", x_waddr, 8'h0A);
        chk("R12", x_wdata, 8'hAE);
        @(negedge clk);
        bop_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_direct;
        t_gpr;
        t_ind0;
        t_ind1;
        t_nested;
        t_reserved;
        t_ext;
        t_bank;
        t_bit;
        t_prio;
        t_bitext;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule